// File: doc/BRIEF.md
# Lane-Striped Vector Add/Multiply Unit

This block runs one vector instruction at a time over a register file that is split element-wise across `LANES` identical lanes. Element `i` of every vector register lives in lane `i % LANES`, at row `i / LANES`. Each lane has its own slice of storage, a pipelined adder and a pipelined multiplier. An operation never reads or writes storage in another lane, so no wires run between lanes. An instruction names a destination register, two source registers, an operation and a vector length. The control then sends one element group per cycle down the lanes: up to `LANES` consecutive elements that move through the pipelines side by side. The block pulses `done` once the last group has been written back.

A simple element-addressed port loads and inspects the registers from outside while the unit is idle. The lane count only sets the speed. The value left in each register element is the same for any lane count that divides the register length.

Top module: `vec_lane_unit`

## Requirements
- R1: While reset is held and after it is released, `busy` and `done` are 0.
- R2: With `opSel` = 0 (add), element i of register `vd` becomes (vs1[i] + vs2[i]) mod 2^EW for every i below the effective length.
- R3: With `opSel` = 1 (multiply), element i of `vd` becomes the low EW bits of vs1[i] * vs2[i] for every i below the effective length.
- R4: Elements of `vd` at index equal to or above the effective length keep their previous values.
- R5: Each issue cycle sends one group of consecutive elements starting at a multiple of LANES. Lanes whose element index is at or above the effective length stay idle. An instruction of length L uses ceil(L/LANES) issue cycles.
- R6: `start` is sampled at a clock edge E0 while `busy` is 0. `busy` is 1 from E0 on. `done` is 1 for exactly the one cycle after edge E0 + ceil(L/LANES) + LAT, where LAT is 1 for add and 3 for multiply. `busy` returns to 0 at that same edge, and the results can be read from then on.
- R7: A length of 0 changes no register. `done` then pulses in the cycle after E0 + 1.
- R8: A `start` seen while `busy` is 1 is ignored and leaves all registers unchanged.
- R9: When `busy` is 0, `wrEn` writes `wrData` into element `wrIdx` of register `wrReg` at the next clock edge. While `busy` is 1, a write is dropped. `rdData` shows element `rdIdx` of register `rdReg` with no clock delay.
- R10: A destination that is also a source gives the same result as if all sources had been read before any element was written.
- R11: A requested length greater than VLEN is treated as VLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an instruction (taken only when idle) |
| opSel | input | 1 | 0 = add, 1 = multiply |
| vd | input | REGW | Destination register |
| vs1 | input | REGW | First source register |
| vs2 | input | REGW | Second source register |
| vl | input | VLW | Requested vector length |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| wrEn | input | 1 | Element write strobe |
| wrReg | input | REGW | Register written |
| wrIdx | input | IDXW | Element index written |
| wrData | input | EW | Element write value |
| rdReg | input | REGW | Register read |
| rdIdx | input | IDXW | Element index read |
| rdData | output | EW | Element read value |

## Verification
With L the effective length, `done` is due ceil(L/LANES)+1 edges after the start edge for add and ceil(L/LANES)+3 for multiply; a length of 0 answers after one edge. The driver records the cycle count at the start edge and queues the expected done cycle. It also queues the full expected register image. The monitor compares the cycle count when it first sees `done` at a falling edge, then reads every element back while the unit is idle, so values are never sampled mid-pipeline. `busy` is checked one cycle after the start edge.

// File: rtl/vecu_pkg.sv
package vecu_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_MUL = 1'b1
  } vop_e;

  // Strobes passed from control to the lane datapath each cycle
  typedef struct packed {
    logic issue;  // an element group is on the lane inputs this cycle
    logic last;   // this group is the final one of the instruction
    vop_e op;     // functional unit that receives the group
  } vstrobe_t;

endpackage

// File: rtl/vecu_ctrl.sv
module vecu_ctrl
  import vecu_pkg::*;
#(
  parameter int LANES = 4,
  parameter int VLEN  = 16,
  parameter int VLW   = 5,
  parameter int ROWW  = 2,
  parameter int REGW  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  vop_e             opIn,
  input  logic [REGW-1:0]  vdIn,
  input  logic [REGW-1:0]  vs1In,
  input  logic [REGW-1:0]  vs2In,
  input  logic [VLW-1:0]   vlIn,
  input  logic             wbLast,
  output vstrobe_t         strb,
  output logic [LANES-1:0] laneEn,
  output logic [ROWW-1:0]  row,
  output logic [REGW-1:0]  vdSel,
  output logic [REGW-1:0]  vs1Sel,
  output logic [REGW-1:0]  vs2Sel,
  output logic             busy,
  output logic             done
);

  logic           busyQ, issuingQ, zeroPendQ, doneQ;
  vop_e           opQ;
  logic [REGW-1:0] vdQ, vs1Q, vs2Q;
  logic [VLW-1:0] vlQ;
  logic [VLW:0]   baseQ;
  logic [ROWW-1:0] rowQ;
  logic [VLW-1:0] vlClamp;
  logic           lastGrp;

  assign vlClamp = (int'(vlIn) > VLEN) ? VLW'(VLEN) : vlIn;
  assign lastGrp = (baseQ + (VLW+1)'(LANES)) >= {1'b0, vlQ};

  for (genvar k = 0; k < LANES; k++) begin : g_en
    assign laneEn[k] = (baseQ + (VLW+1)'(k)) < {1'b0, vlQ};
  end

  assign strb   = '{issue: issuingQ, last: lastGrp, op: opQ};
  assign row    = rowQ;
  assign vdSel  = vdQ;
  assign vs1Sel = vs1Q;
  assign vs2Sel = vs2Q;
  assign busy   = busyQ;
  assign done   = doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      issuingQ  <= 1'b0;
      zeroPendQ <= 1'b0;
      doneQ     <= 1'b0;
      opQ       <= OP_ADD;
      vdQ       <= '0;
      vs1Q      <= '0;
      vs2Q      <= '0;
      vlQ       <= '0;
      baseQ     <= '0;
      rowQ      <= '0;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ) begin
        if (start) begin
          busyQ     <= 1'b1;
          opQ       <= opIn;
          vdQ       <= vdIn;
          vs1Q      <= vs1In;
          vs2Q      <= vs2In;
          vlQ       <= vlClamp;
          baseQ     <= '0;
          rowQ      <= '0;
          issuingQ  <= (vlClamp != '0);
          zeroPendQ <= (vlClamp == '0);
        end
      end else begin
        if (issuingQ) begin
          if (lastGrp) begin
            issuingQ <= 1'b0;
          end else begin
            baseQ <= baseQ + (VLW+1)'(LANES);
            rowQ  <= rowQ + 1'b1;
          end
        end
        if (zeroPendQ || wbLast) begin
          doneQ     <= 1'b1;
          busyQ     <= 1'b0;
          zeroPendQ <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/vecu_datapath.sv
module vecu_datapath
  import vecu_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int ROWS    = 4,
  parameter int NREGS   = 4,
  parameter int EW      = 16,
  parameter int ADD_LAT = 1,
  parameter int MUL_LAT = 3,
  parameter int ROWW    = 2,
  parameter int REGW    = 2,
  parameter int IDXW    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  vstrobe_t         strb,
  input  logic [LANES-1:0] laneEn,
  input  logic [ROWW-1:0]  row,
  input  logic [REGW-1:0]  vdSel,
  input  logic [REGW-1:0]  vs1Sel,
  input  logic [REGW-1:0]  vs2Sel,
  input  logic             hostWe,
  input  logic [REGW-1:0]  hostReg,
  input  logic [IDXW-1:0]  hostIdx,
  input  logic [EW-1:0]    hostData,
  input  logic [REGW-1:0]  rdReg,
  input  logic [IDXW-1:0]  rdIdx,
  output logic [EW-1:0]    rdData,
  output logic             wbLast
);

  localparam int LANEW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [EW-1:0]    laneRd   [LANES];
  logic [LANES-1:0] laneLast;
  logic [ROWW-1:0]  hostRow, rdRow;
  logic [LANEW-1:0] hostLane, rdLane;

  assign hostRow  = ROWW'(hostIdx / IDXW'(LANES));
  assign hostLane = LANEW'(hostIdx % IDXW'(LANES));
  assign rdRow    = ROWW'(rdIdx / IDXW'(LANES));
  assign rdLane   = LANEW'(rdIdx % IDXW'(LANES));

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [EW-1:0] rf [NREGS][ROWS];
    logic [EW-1:0] opA, opB, sum, prodLo;

    logic [ADD_LAT-1:0] aVal, aLast;
    logic [ROWW-1:0]    aRow [ADD_LAT];
    logic [REGW-1:0]    aVd  [ADD_LAT];
    logic [EW-1:0]      aRes [ADD_LAT];

    logic [MUL_LAT-1:0] mVal, mLast;
    logic [ROWW-1:0]    mRow [MUL_LAT];
    logic [REGW-1:0]    mVd  [MUL_LAT];
    logic [EW-1:0]      mRes [MUL_LAT];

    assign opA    = rf[vs1Sel][row];
    assign opB    = rf[vs2Sel][row];
    assign sum    = opA + opB;
    assign prodLo = opA * opB;

    // adder pipeline
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        aVal  <= '0;
        aLast <= '0;
      end else begin
        aVal[0]  <= strb.issue && (strb.op == OP_ADD) && laneEn[k];
        aLast[0] <= strb.last;
        aRow[0]  <= row;
        aVd[0]   <= vdSel;
        aRes[0]  <= sum;
        for (int s = 1; s < ADD_LAT; s++) begin
          aVal[s]  <= aVal[s-1];
          aLast[s] <= aLast[s-1];
          aRow[s]  <= aRow[s-1];
          aVd[s]   <= aVd[s-1];
          aRes[s]  <= aRes[s-1];
        end
      end
    end

    // multiplier pipeline
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mVal  <= '0;
        mLast <= '0;
      end else begin
        mVal[0]  <= strb.issue && (strb.op == OP_MUL) && laneEn[k];
        mLast[0] <= strb.last;
        mRow[0]  <= row;
        mVd[0]   <= vdSel;
        mRes[0]  <= prodLo;
        for (int s = 1; s < MUL_LAT; s++) begin
          mVal[s]  <= mVal[s-1];
          mLast[s] <= mLast[s-1];
          mRow[s]  <= mRow[s-1];
          mVd[s]   <= mVd[s-1];
          mRes[s]  <= mRes[s-1];
        end
      end
    end

    // write-back into this lane's slice; one instruction in flight at a time
    always_ff @(posedge clk) begin
      if (aVal[ADD_LAT-1]) begin
        rf[aVd[ADD_LAT-1]][aRow[ADD_LAT-1]] <= aRes[ADD_LAT-1];
      end else if (mVal[MUL_LAT-1]) begin
        rf[mVd[MUL_LAT-1]][mRow[MUL_LAT-1]] <= mRes[MUL_LAT-1];
      end else if (hostWe && (hostLane == LANEW'(k))) begin
        rf[hostReg][hostRow] <= hostData;
      end
    end

    assign laneLast[k] = (aVal[ADD_LAT-1] && aLast[ADD_LAT-1]) ||
                         (mVal[MUL_LAT-1] && mLast[MUL_LAT-1]);
    assign laneRd[k]   = rf[rdReg][rdRow];
  end

  assign wbLast = |laneLast;
  assign rdData = laneRd[rdLane];

endmodule

// File: rtl/vec_lane_unit.sv
module vec_lane_unit
  import vecu_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int VLEN    = 16,
  parameter int NREGS   = 4,
  parameter int EW      = 16,
  parameter int ADD_LAT = 1,
  parameter int MUL_LAT = 3,
  localparam int ROWS   = VLEN / LANES,
  localparam int ROWW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int REGW   = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int IDXW   = (VLEN > 1) ? $clog2(VLEN) : 1,
  localparam int VLW    = $clog2(VLEN + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            opSel,
  input  logic [REGW-1:0] vd,
  input  logic [REGW-1:0] vs1,
  input  logic [REGW-1:0] vs2,
  input  logic [VLW-1:0]  vl,
  output logic            busy,
  output logic            done,
  input  logic            wrEn,
  input  logic [REGW-1:0] wrReg,
  input  logic [IDXW-1:0] wrIdx,
  input  logic [EW-1:0]   wrData,
  input  logic [REGW-1:0] rdReg,
  input  logic [IDXW-1:0] rdIdx,
  output logic [EW-1:0]   rdData
);

  vstrobe_t         strb;
  logic [LANES-1:0] laneEn;
  logic [ROWW-1:0]  rowSel;
  logic [REGW-1:0]  vdSel, vs1Sel, vs2Sel;
  logic             wbLast;
  logic             hostWe;

  assign hostWe = wrEn && !busy;

  vecu_ctrl #(
    .LANES(LANES), .VLEN(VLEN), .VLW(VLW), .ROWW(ROWW), .REGW(REGW)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .opIn(vop_e'(opSel)),
    .vdIn(vd), .vs1In(vs1), .vs2In(vs2), .vlIn(vl), .wbLast(wbLast),
    .strb(strb), .laneEn(laneEn), .row(rowSel), .vdSel(vdSel),
    .vs1Sel(vs1Sel), .vs2Sel(vs2Sel), .busy(busy), .done(done)
  );

  vecu_datapath #(
    .LANES(LANES), .ROWS(ROWS), .NREGS(NREGS), .EW(EW),
    .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT),
    .ROWW(ROWW), .REGW(REGW), .IDXW(IDXW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .laneEn(laneEn), .row(rowSel),
    .vdSel(vdSel), .vs1Sel(vs1Sel), .vs2Sel(vs2Sel),
    .hostWe(hostWe), .hostReg(wrReg), .hostIdx(wrIdx), .hostData(wrData),
    .rdReg(rdReg), .rdIdx(rdIdx), .rdData(rdData), .wbLast(wbLast)
  );

endmodule

// File: rtl/vecu_checker.sv
module vecu_checker
  import vecu_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int ADD_LAT = 1,
  parameter int MUL_LAT = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input vstrobe_t         strb,
  input logic [LANES-1:0] laneEn,
  input logic             wbLast
);

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: completion ends a busy period
  p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R6: busy only begins on a start request
  p_busy_from_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R6: final write-back is followed by the done pulse
  p_wb_to_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    wbLast |=> done);

  // R6: add latency from last group issue to final write-back
  p_add_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && strb.last && strb.op == OP_ADD) |-> ##ADD_LAT wbLast);

  // R6: multiply latency from last group issue to final write-back
  p_mul_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && strb.last && strb.op == OP_MUL) |-> ##MUL_LAT wbLast);

  // R5: groups are only issued while an instruction is running
  p_issue_in_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> busy);

  // R5: lane 0 always carries an element of an issued group
  p_lane0_active_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> laneEn[0]);

  // R5: enabled lanes form a prefix
  p_lane_prefix_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> ((laneEn & LANES'(laneEn + 1'b1)) == '0));

  // R5: only the final group may be partial
  p_full_before_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && !strb.last) |-> (&laneEn));

endmodule

bind vec_lane_unit vecu_checker #(
  .LANES(LANES), .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)
) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .strb(strb), .laneEn(laneEn), .wbLast(wbLast)
);

// File: tb/vec_lane_unit_tb_top.sv
module vec_lane_unit_tb_top;

  localparam int LANES = 4;
  localparam int VLEN  = 16;
  localparam int NREGS = 4;
  localparam int EW    = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic opSel = 1'b0;
  logic [1:0] vd = '0, vs1 = '0, vs2 = '0;
  logic [4:0] vl = '0;
  logic busy, done;
  logic wrEn = 1'b0;
  logic [1:0] wrReg = '0;
  logic [3:0] wrIdx = '0;
  logic [15:0] wrData = '0;
  logic [1:0] rdReg = '0;
  logic [3:0] rdIdx = '0;
  logic [15:0] rdData;

  int checks = 0;
  int failures = 0;
  int cycleCount = 0;
  bit monDone = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    int r;
    int i;
    int v;
    string tag;
  } elemExp_t;

  typedef struct {
    int cyc;
    string tag;
  } doneExp_t;

  elemExp_t expQ[$];
  doneExp_t doneQ[$];
  int model[NREGS][VLEN];

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) cycleCount <= cycleCount + 1;

  vec_lane_unit #(
    .LANES(LANES), .VLEN(VLEN), .NREGS(NREGS), .EW(EW)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .vd(vd), .vs1(vs1), .vs2(vs2), .vl(vl), .busy(busy), .done(done),
    .wrEn(wrEn), .wrReg(wrReg), .wrIdx(wrIdx), .wrData(wrData),
    .rdReg(rdReg), .rdIdx(rdIdx), .rdData(rdData)
  );

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic hostWrite(int r, int i, int v);
    @(negedge clk);
    wrEn = 1'b1; wrReg = 2'(r); wrIdx = 4'(i); wrData = 16'(v);
    @(negedge clk);
    wrEn = 1'b0;
    model[r][i] = v;
  endtask

  // Driver: computes expected image and completion cycle, then issues
  task automatic runInstr(bit op, int d, int s1, int s2, int len, int mode,
                          string tag, string otherTag);
    int vlEff, grp, lat, n;
    int nv[VLEN];
    vlEff = (len > VLEN) ? VLEN : len;
    for (int i = 0; i < VLEN; i++) begin
      if (i < vlEff)
        nv[i] = op ? ((model[s1][i] * model[s2][i]) & 16'hFFFF)
                   : ((model[s1][i] + model[s2][i]) & 16'hFFFF);
      else
        nv[i] = model[d][i];
    end
    for (int i = 0; i < VLEN; i++) model[d][i] = nv[i];
    for (int r = 0; r < NREGS; r++) begin
      for (int i = 0; i < VLEN; i++) begin
        elemExp_t e;
        e.r = r; e.i = i; e.v = model[r][i];
        e.tag = (r != d) ? otherTag : ((i < vlEff) ? tag : "R4");
        expQ.push_back(e);
      end
    end
    grp = (vlEff + LANES - 1) / LANES;
    lat = op ? 3 : 1;
    monDone = 1'b0;
    @(negedge clk);
    start = 1'b1; opSel = op; vd = 2'(d); vs1 = 2'(s1); vs2 = 2'(s2); vl = 5'(len);
    n = cycleCount;
    begin
      doneExp_t de;
      de.cyc = (vlEff == 0) ? n + 2 : n + 1 + grp + lat;
      de.tag = (vlEff == 0) ? "R7" : "R6";
      doneQ.push_back(de);
    end
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R6 busy", int'(busy), 1);
    if (mode == 1) begin
      // a second start while busy, aimed at register 2 (must be ignored)
      start = 1'b1; opSel = 1'b1; vd = 2'd2; vs1 = 2'd0; vs2 = 2'd1; vl = 5'd16;
      @(negedge clk);
      start = 1'b0;
    end else if (mode == 2) begin
      // a write while busy (must be dropped)
      wrEn = 1'b1; wrReg = 2'd0; wrIdx = 4'd0; wrData = 16'hBEEF;
      @(negedge clk);
      wrEn = 1'b0;
    end
    wait (monDone);
  endtask

  // Monitor: checks completion cycle, then compares the register image
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (doneQ.size() == 0) begin
          check(1'b0, "R6 unexpected done", 1, 0);
        end else begin
          doneExp_t de;
          de = doneQ.pop_front();
          check(cycleCount == de.cyc, de.tag, cycleCount, de.cyc);
          check(busy == 1'b0, "R6 busy at done", int'(busy), 0);
        end
        while (expQ.size() > 0) begin
          elemExp_t e;
          e = expQ.pop_front();
          rdReg = 2'(e.r); rdIdx = 4'(e.i);
          #1;
          check(int'(rdData) == e.v, e.tag, int'(rdData), e.v);
        end
        monDone = 1'b1;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycleCount, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);

    // R9: load every element through the host port while idle
    for (int r = 0; r < NREGS; r++)
      for (int i = 0; i < VLEN; i++)
        hostWrite(r, i, (r * 4099 + i * 517 + 33) & 16'hFFFF);

    runInstr(1'b0, 2, 0, 1, 16, 0, "R2", "R9");   // full add
    runInstr(1'b1, 3, 0, 1, 16, 0, "R3", "R9");   // full multiply, wraps
    runInstr(1'b0, 2, 1, 3, 6,  0, "R5", "R4");   // partial final group
    runInstr(1'b1, 1, 2, 3, 1,  0, "R3", "R4");   // single element
    runInstr(1'b0, 0, 1, 2, 0,  0, "R7", "R7");   // zero length
    runInstr(1'b0, 0, 0, 2, 9,  0, "R10", "R9");  // destination is a source
    runInstr(1'b1, 3, 1, 2, 16, 1, "R3", "R8");   // start while busy
    runInstr(1'b0, 1, 2, 3, 16, 2, "R2", "R9");   // write while busy
    runInstr(1'b0, 2, 0, 1, 31, 0, "R11", "R9");  // length clamped
    runInstr(1'b1, 0, 0, 0, 13, 0, "R10", "R9");  // square in place

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule